// File: doc/BRIEF.md
# Sequential Signed Multiply/Divide Unit

This block performs two's-complement multiply and divide on W-bit words (16 by default) through one shared iterative datapath. A single-cycle `start` pulse together with `op_div` picks the operation. Multiply forms the signed product of the A word and an operand word and returns it as a double word split across B (upper half) and A (lower half). Divide treats B:A as a signed double-word dividend and the operand as a signed divisor. It returns a truncated quotient in A, a remainder in B, and an overflow flag set by fixed rules.

Both operations run on magnitudes. A setup cycle takes absolute values and records signs. W shift/add (multiply) or restoring shift/subtract (divide) cycles follow, and then a fix-up cycle applies the signs and registers the results. A divide whose upper dividend magnitude is not below the divisor magnitude is flagged at setup and skips the iterations. Its result is then the dividend magnitude itself. Every operation has the same latency, and `done` is high for exactly one cycle when the outputs update.

Top module: `smd_unit`

## Requirements
- R1: Multiply (`op_div`=0) returns the signed product of `a_in` and `opnd_in`, each sign-extended to 2W bits. The upper W bits go to `b_out` and the lower W bits go to `a_out`.
- R2: A multiply always leaves `ovf_out` at 0.
- R3: A divide (`op_div`=1) takes the dividend {`b_in`,`a_in`} and negates it as a 2W-bit value when negative. If the upper W bits of that magnitude are at least the divisor magnitude, `ovf_out`=1 and the magnitude is returned unchanged: upper word on `b_out`, lower word on `a_out`.
- R4: A zero divisor always takes the R3 overflow path.
- R5: Otherwise the unsigned division of the magnitudes gives quotient and remainder. The quotient is negated when exactly one of dividend and divisor is negative. The remainder is negated when the dividend is negative. Quotient goes to `a_out`, remainder to `b_out`.
- R6: After its sign is applied, a nonzero quotient whose bit W-1 differs from the expected quotient sign sets `ovf_out`=1. A zero quotient never sets it.
- R7: A negative dividend yields a negated remainder even when the quotient is zero.
- R8: `done` goes high for exactly one cycle, W+1 rising edges after the edge that accepts `start`. The outputs change only at that edge and hold until the next result.
- R9: A `start` pulse while an operation is in progress is ignored: neither the result nor the timing of that operation changes.
- R10: After reset `a_out`, `b_out` and `ovf_out` are 0 and `done` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request; accepted only while idle |
| op_div | input | 1 | 0 = multiply, 1 = divide |
| a_in | input | W | A word: multiplicand, or low dividend word |
| b_in | input | W | B word: high dividend word (unused by multiply) |
| opnd_in | input | W | Multiplier or divisor word |
| a_out | output | W | Low product word or quotient |
| b_out | output | W | High product word or remainder |
| ovf_out | output | 1 | Overflow flag |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Every result is due W+1 rising edges after the edge that samples `start`. No output may move before that edge, and `done` must fall again one edge later. The bench drives stimulus on falling edges and counts falling edges from the start pulse. It checks that `done` is low one sample early, compares all three outputs with arithmetic expectations at the sample where `done` is high, and checks that `done` is low one sample after. The same fixed count applies to multiply, normal divide and the early-overflow divide. The expectations cover extreme dividends and divisors, a zero divisor, and a second `start` issued mid-operation.

// File: rtl/smd_pkg.sv
package smd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ITER = 2'd1,
      ST_POST = 2'd2
   } smd_state_t;
endpackage

// File: rtl/smd_sign_prep.sv
// Setup stage: converts operands to magnitudes, records result signs and
// performs the early divide-overflow comparison.
module smd_sign_prep #(
   parameter int W = 16
) (
   input  logic         is_div,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] opnd,
   output logic [W-1:0] hi0,
   output logic [W-1:0] lo0,
   output logic [W-1:0] mag_op,
   output logic         neg_q,
   output logic         neg_r,
   output logic         pre_ovf
);
   logic [W-1:0] a_mag;
   logic [W-1:0] lo_neg;
   logic [W-1:0] hi_neg;
   logic [W-1:0] d_hi;
   logic [W-1:0] d_lo;

   always_comb begin
      a_mag  = a[W-1] ? (~a + W'(1)) : a;
      mag_op = opnd[W-1] ? (~opnd + W'(1)) : opnd;
      // double-word negate: low word negated, high word complemented and
      // bumped only when the negated low word is zero
      lo_neg = ~a + W'(1);
      hi_neg = ~b + W'(lo_neg == '0);
      d_hi   = b[W-1] ? hi_neg : b;
      d_lo   = b[W-1] ? lo_neg : a;
      if (is_div) begin
         hi0     = d_hi;
         lo0     = d_lo;
         neg_q   = b[W-1] ^ opnd[W-1];
         neg_r   = b[W-1];
         pre_ovf = (d_hi >= mag_op);
      end else begin
         hi0     = '0;
         lo0     = a_mag;
         neg_q   = a[W-1] ^ opnd[W-1];
         neg_r   = 1'b0;
         pre_ovf = 1'b0;
      end
   end
endmodule

// File: rtl/smd_mul_step.sv
// One shift/add step: {hi,lo} holds partial product over remaining multiplier bits.
module smd_mul_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] m,
   output logic [W-1:0] hi_n,
   output logic [W-1:0] lo_n
);
   logic [W:0] sum;

   always_comb begin
      sum  = {1'b0, hi} + (lo[0] ? {1'b0, m} : '0);
      hi_n = sum[W:1];
      lo_n = {sum[0], lo[W-1:1]};
   end
endmodule

// File: rtl/smd_div_step.sv
// One restoring step: hi is the partial remainder, lo shifts dividend bits out
// and quotient bits in.
module smd_div_step #(
   parameter int W = 16
) (
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   input  logic [W-1:0] m,
   output logic [W-1:0] hi_n,
   output logic [W-1:0] lo_n
);
   logic [W:0] trial;
   logic [W:0] diff;
   logic       fits;

   always_comb begin
      trial = {hi, lo[W-1]};
      diff  = trial - {1'b0, m};
      fits  = (trial >= {1'b0, m});
      hi_n  = fits ? diff[W-1:0] : trial[W-1:0];
      lo_n  = {lo[W-2:0], fits};
   end
endmodule

// File: rtl/smd_fixup.sv
// Final stage: applies signs and the post-sign quotient overflow rule.
module smd_fixup #(
   parameter int W = 16
) (
   input  logic         is_div,
   input  logic         pre_ovf,
   input  logic         neg_q,
   input  logic         neg_r,
   input  logic [W-1:0] hi,
   input  logic [W-1:0] lo,
   output logic [W-1:0] a_res,
   output logic [W-1:0] b_res,
   output logic         ovf_res
);
   localparam int DW = 2 * W;

   logic [DW-1:0] prod;
   logic [W-1:0]  quo;

   always_comb begin
      prod    = neg_q ? (~{hi, lo} + DW'(1)) : {hi, lo};
      quo     = (neg_q && lo != '0) ? (~lo + W'(1)) : lo;
      a_res   = '0;
      b_res   = '0;
      ovf_res = 1'b0;
      if (!is_div) begin
         a_res = prod[W-1:0];
         b_res = prod[DW-1:W];
      end else if (pre_ovf) begin
         a_res   = lo;
         b_res   = hi;
         ovf_res = 1'b1;
      end else begin
         a_res   = quo;
         b_res   = neg_r ? (~hi + W'(1)) : hi;
         ovf_res = (lo != '0) && (quo[W-1] != neg_q);
      end
   end
endmodule

// File: rtl/smd_unit.sv
module smd_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         op_div,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   input  logic [W-1:0] opnd_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] b_out,
   output logic         ovf_out,
   output logic         done
);
   import smd_pkg::*;

   localparam int              CNTW = $clog2(W);
   localparam logic [CNTW-1:0] LAST = CNTW'(W - 1);

   generate
      if (W < 4) begin : g_width_check
         $error("smd_unit: W must be at least 4");
      end
   endgenerate

   smd_state_t    st;
   logic [CNTW-1:0] cnt;
   logic          div_q, negq_q, negr_q, povf_q;
   logic [W-1:0]  hi_q, lo_q, m_q;

   logic [W-1:0]  p_hi, p_lo, p_m;
   logic          p_negq, p_negr, p_povf;
   logic [W-1:0]  mu_hi, mu_lo, dv_hi, dv_lo;
   logic [W-1:0]  f_a, f_b;
   logic          f_o;

   smd_sign_prep #(.W(W)) u_prep (
      .is_div(op_div), .a(a_in), .b(b_in), .opnd(opnd_in),
      .hi0(p_hi), .lo0(p_lo), .mag_op(p_m),
      .neg_q(p_negq), .neg_r(p_negr), .pre_ovf(p_povf)
   );

   smd_mul_step #(.W(W)) u_mul (
      .hi(hi_q), .lo(lo_q), .m(m_q), .hi_n(mu_hi), .lo_n(mu_lo)
   );

   smd_div_step #(.W(W)) u_div (
      .hi(hi_q), .lo(lo_q), .m(m_q), .hi_n(dv_hi), .lo_n(dv_lo)
   );

   smd_fixup #(.W(W)) u_fix (
      .is_div(div_q), .pre_ovf(povf_q), .neg_q(negq_q), .neg_r(negr_q),
      .hi(hi_q), .lo(lo_q), .a_res(f_a), .b_res(f_b), .ovf_res(f_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cnt     <= '0;
         div_q   <= 1'b0;
         negq_q  <= 1'b0;
         negr_q  <= 1'b0;
         povf_q  <= 1'b0;
         hi_q    <= '0;
         lo_q    <= '0;
         m_q     <= '0;
         a_out   <= '0;
         b_out   <= '0;
         ovf_out <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (start) begin
                  div_q  <= op_div;
                  hi_q   <= p_hi;
                  lo_q   <= p_lo;
                  m_q    <= p_m;
                  negq_q <= p_negq;
                  negr_q <= p_negr;
                  povf_q <= p_povf;
                  cnt    <= '0;
                  st     <= ST_ITER;
               end
            end
            ST_ITER: begin
               // early-overflow divides keep the magnitudes untouched
               if (!(div_q && povf_q)) begin
                  hi_q <= div_q ? dv_hi : mu_hi;
                  lo_q <= div_q ? dv_lo : mu_lo;
               end
               cnt <= cnt + CNTW'(1);
               if (cnt == LAST) st <= ST_POST;
            end
            ST_POST: begin
               a_out   <= f_a;
               b_out   <= f_b;
               ovf_out <= f_o;
               done    <= 1'b1;
               st      <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_post_gives_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_POST) |=> done);

   assert_mul_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !div_q) |-> !ovf_out);

   assert_zero_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE && start && op_div && opnd_in == '0) |=> povf_q);

   assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (st != ST_IDLE) |=> ($stable(m_q) && $stable(div_q)));
endmodule

// File: tb/sim_smd_unit.sv
`timescale 1ns/1ps
module sim_smd_unit;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start = 1'b0;
   logic         op_div = 1'b0;
   logic [W-1:0] a_in = '0;
   logic [W-1:0] b_in = '0;
   logic [W-1:0] opnd_in = '0;
   logic [W-1:0] a_out, b_out;
   logic         ovf_out, done;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   smd_unit #(.W(W)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_div(op_div),
      .a_in(a_in), .b_in(b_in), .opnd_in(opnd_in),
      .a_out(a_out), .b_out(b_out), .ovf_out(ovf_out), .done(done)
   );

   task automatic chk(input logic ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [32:0] model_mul(input logic [15:0] a, input logic [15:0] op);
      logic signed [63:0] p;
      p = 64'($signed(a)) * 64'($signed(op));
      return {1'b0, p[31:16], p[15:0]};
   endfunction

   function automatic logic [32:0] model_div(input logic [15:0] a, input logic [15:0] b,
                                             input logic [15:0] op);
      logic signed [31:0] d32;
      logic signed [63:0] dd, o, mag, dvm, q, r;
      logic [15:0] qq, rr;
      logic qs, ov;
      d32 = {b, a};
      dd  = 64'(d32);
      o   = 64'($signed(op));
      mag = (dd < 0) ? -dd : dd;
      dvm = (o < 0) ? -o : o;
      if ({48'd0, mag[31:16]} >= dvm) return {1'b1, mag[31:16], mag[15:0]};
      q  = mag / dvm;
      r  = mag % dvm;
      qs = (dd < 0) ^ (o < 0);
      qq = q[15:0];
      if (qq != 0 && qs) qq = -qq;
      ov = (qq != 0) && (qq[15] != qs);
      rr = r[15:0];
      if (dd < 0) rr = -rr;
      return {ov, rr, qq};
   endfunction

   task automatic run_op(input logic dv, input logic [15:0] a, input logic [15:0] b,
                         input logic [15:0] op, input string tag);
      logic [32:0] e;
      e = dv ? model_div(a, b, op) : model_mul(a, op);
      @(negedge clk);
      start = 1'b1; op_div = dv; a_in = a; b_in = b; opnd_in = op;
      @(negedge clk);
      start = 1'b0;
      repeat (W) @(negedge clk);
      chk(!done, "R8", "done early", 64'(done), 64'd0);
      @(negedge clk);
      chk(done, "R8", "done due", 64'(done), 64'd1);
      chk({ovf_out, b_out, a_out} == e, tag, "ovf,B,A",
          64'({ovf_out, b_out, a_out}), 64'(e));
      @(negedge clk);
      chk(!done, "R8", "done width", 64'(done), 64'd0);
   endtask

   function automatic string div_tag(input logic [15:0] a, input logic [15:0] b,
                                     input logic [15:0] op);
      logic [32:0] e;
      e = model_div(a, b, op);
      if (op == 0) return "R4";
      if (e[32] && e[31:0] == 32'(0)) return "R3";
      return e[32] ? "R3_R6" : "R5";
   endfunction

   logic [15:0] vals [12];
   logic [15:0] lows [4];

   initial begin
      vals = '{16'h0000, 16'h0001, 16'h0002, 16'h0003, 16'h0007, 16'h7FFF,
               16'h8000, 16'h8001, 16'hFFFF, 16'hFFFE, 16'h1234, 16'hFF00};
      lows = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF};
      repeat (3) @(negedge clk);
      // R10 reset state
      chk(a_out == 0 && b_out == 0 && !ovf_out && !done, "R10", "reset outputs",
          64'({done, ovf_out, b_out, a_out}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 multiply sweep
      foreach (vals[i]) foreach (vals[j]) run_op(1'b0, vals[i], 16'h5A5A, vals[j], "R1_R2");

      // directed divide corners
      run_op(1'b1, 16'h8000, 16'h0000, 16'h0001, "R6");   // +32768/1 overflows after sign
      run_op(1'b1, 16'h8000, 16'hFFFF, 16'h0001, "R6");   // -32768/1 fits
      run_op(1'b1, 16'hFFFB, 16'hFFFF, 16'h0007, "R7");   // -5/7: q=0, r=-5
      run_op(1'b1, 16'h1234, 16'h0005, 16'h0000, "R4");   // zero divisor
      run_op(1'b1, 16'h0000, 16'h8000, 16'h8000, "R3");   // most negative dividend
      run_op(1'b1, 16'h0064, 16'h0000, 16'hFFF9, "R5");   // 100 / -7

      // divide sweep
      foreach (vals[i]) foreach (lows[k]) foreach (vals[j])
         run_op(1'b1, lows[k], vals[i], vals[j], div_tag(lows[k], vals[i], vals[j]));

      // pseudo-random mix
      begin
         logic [31:0] s;
         s = 32'h1ACE_B00C;
         for (int n = 0; n < 300; n++) begin
            logic [15:0] ra, rb, ro;
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ra = s[15:0]; rb = s[31:16];
            s = s ^ (s << 13); s = s ^ (s >> 17); s = s ^ (s << 5);
            ro = (n % 3 == 0) ? {8'h00, s[7:0]} : s[15:0];
            if (n % 2 == 0) run_op(1'b0, ra, rb, ro, "R1");
            else            run_op(1'b1, ra, rb, ro, div_tag(ra, rb, ro));
         end
      end

      // R9: second start during an operation is ignored
      begin
         logic [32:0] e;
         e = model_div(16'h0064, 16'h0000, 16'h0007);
         @(negedge clk);
         start = 1'b1; op_div = 1'b1; a_in = 16'h0064; b_in = 16'h0000; opnd_in = 16'h0007;
         @(negedge clk);
         start = 1'b0;
         repeat (3) @(negedge clk);
         start = 1'b1; op_div = 1'b0; a_in = 16'h0003; opnd_in = 16'h0005;
         @(negedge clk);
         start = 1'b0;
         repeat (W - 4) @(negedge clk);
         chk(!done, "R9", "done early", 64'(done), 64'd0);
         @(negedge clk);
         chk(done, "R9", "done due", 64'(done), 64'd1);
         chk({ovf_out, b_out, a_out} == e, "R9", "result kept",
             64'({ovf_out, b_out, a_out}), 64'(e));
         repeat (W + 3) @(negedge clk);
         chk(!done, "R9", "no second result", 64'(done), 64'd0);
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL R8 watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule